// File: doc/BRIEF.md
# Exact Wide-Register Multiply-Accumulate

This block forms a running sum of floating-point products without any intermediate rounding. Each operand pair is multiplied exactly, the full product is aligned by the sum of the two exponents, and it is added to or subtracted from a long two's complement fixed-point register. Heavy cancellation between large terms therefore leaves the small residue exact. Only one rounding step is applied. It happens when the caller asks for the result, and it rounds to nearest, ties to even.

The long register is stored as words with per-word valid flags. A product touches only the window of words that its exponent selects, so every update stays narrow. The carry or borrow out of a window is not rippled through the upper words at once. It is parked in a small signed counter on the next word and is resolved later. Consecutive products go round-robin to four partial-sum banks. On finish, the block combines the banks word by word, from the least significant word upward, with one running carry. It then normalizes the sum, rounds it and presents it with a one-cycle done pulse.

Operands are packed as sign, biased exponent and fraction, with a hidden leading one. An exponent field of zero encodes zero. The result is packed as sign, a wider exponent and a fraction of the operand's width.

Top module: `xacc_mac`

## Requirements
- R1: The result equals the exact signed sum of all accepted products since the last clear, taken modulo 2^ACC_W and rounded once. A product is ({1,frac_a}·{1,frac_b})·2^(exp_a+exp_b) in accumulator units. An operand is {sign[OP_W-1], exp[OP_W-2 -: EXP_W], frac[FRAC_W-1:0]}.
- R2: An operand whose exponent field is 0 is zero, and such a pair adds nothing to the sum.
- R3: Accepted pairs go to the partial-sum banks in rotation. At most one bank is written per cycle, and no bank is written in two consecutive cycles. Pairs presented every cycle are all counted.
- R4: The sign of the product is the XOR of the operand signs. A negative total gives sign bit 1 and the magnitude of the total.
- R5: Clear empties the sum in one cycle. A pair presented in the same cycle as clear is part of the new sum. A pair presented in the cycle before clear is discarded.
- R6: The result is {sign[RES_W-1], exp[RES_W-2 -: OUT_EXP_W], frac[FRAC_W-1:0]}. Here exp is L+1, where L is the index of the leading one of the magnitude, and frac holds the FRAC_W bits below L. A zero total gives an all-zero result.
- R7: done_o rises exactly NW+2 cycles after the edge that accepts finish_i, with NW = ACC_W/WORD_W. A pair presented together with finish_i is included.
- R8: done_o is high for one cycle. res_o changes only together with done_o and holds its value until the next done_o. After reset, both are 0.
- R9: While a finish pass runs, in_valid_i, clear_i and finish_i have no effect.
- R10: Finish does not empty the sum. Later pairs add to the same total.
- R11: Rounding is to nearest. On an exact tie it goes to the even fraction, and a carry out of the fraction raises exp by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair present |
| op_a_i | input | OP_W | First operand |
| op_b_i | input | OP_W | Second operand |
| clear_i | input | 1 | Empty the running sum |
| finish_i | input | 1 | Start the combine-and-round pass |
| res_o | output | RES_W | Rounded sum |
| done_o | output | 1 | One-cycle pulse, res_o updated |

## Verification
Clear and an operand pair can meet in one cycle. A second case is a pair presented in the cycle just before clear, while the bank write for that pair coincides with the clear edge. The bench sends one pair followed directly by a second pair with clear raised. It then expects the finished result to equal the rounded second product alone. Finish can also arrive together with a pair. That case is judged from the result value and from the exact cycle count to done.

// File: rtl/xacc_pkg.sv
package xacc_pkg;

   typedef enum logic [1:0] {
      FP_IDLE,
      FP_DRAIN,
      FP_SUM,
      FP_ROUND
   } fpass_e;

endpackage

// File: rtl/xacc_prod.sv
module xacc_prod #(
   parameter int EXP_W  = 7,
   parameter int FRAC_W = 23,
   parameter int WORD_W = 32,
   parameter int WIN_N  = 3,
   parameter int IDX_W  = 4,
   parameter int SEL_W  = 2,
   localparam int OP_W   = 1 + EXP_W + FRAC_W,
   localparam int PROD_W = 2 * (FRAC_W + 1),
   localparam int SH_W   = $clog2(WORD_W),
   localparam int POS_W  = EXP_W + 1,
   localparam int WIN_W  = WIN_N * WORD_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              take_i,
   input  logic [OP_W-1:0]   op_a_i,
   input  logic [OP_W-1:0]   op_b_i,
   input  logic [SEL_W-1:0]  sel_i,
   output logic              pv_o,
   output logic              psub_o,
   output logic [IDX_W-1:0]  pidx_o,
   output logic [WIN_W-1:0]  pwin_o,
   output logic [SEL_W-1:0]  psel_o
);

   logic [EXP_W-1:0]  ea, eb;
   logic [PROD_W-1:0] sa, sb, prod;
   logic [POS_W-1:0]  pos;
   logic              is_zero;
   logic [WIN_W-1:0]  win;

   assign ea      = op_a_i[OP_W-2 -: EXP_W];
   assign eb      = op_b_i[OP_W-2 -: EXP_W];
   assign is_zero = (ea == '0) || (eb == '0);
   assign sa      = PROD_W'({1'b1, op_a_i[FRAC_W-1:0]});
   assign sb      = PROD_W'({1'b1, op_b_i[FRAC_W-1:0]});
   assign prod    = sa * sb;
   assign pos     = POS_W'(ea) + POS_W'(eb);
   assign win     = is_zero ? '0 : (WIN_W'(prod) << pos[SH_W-1:0]);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pv_o <= 1'b0;
      end else begin
         pv_o <= take_i;
      end
   end

   always_ff @(posedge clk_i) begin
      if (take_i) begin
         psub_o <= op_a_i[OP_W-1] ^ op_b_i[OP_W-1];
         pidx_o <= IDX_W'(pos >> SH_W);
         pwin_o <= win;
         psel_o <= sel_i;
      end
   end

endmodule

// File: rtl/xacc_bank.sv
module xacc_bank #(
   parameter int NW      = 16,
   parameter int WORD_W  = 32,
   parameter int CARRY_W = 8,
   parameter int WIN_N   = 3,
   parameter int IDX_W   = 4,
   localparam int WIN_W  = WIN_N * WORD_W
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               clr_i,
   input  logic               we_i,
   input  logic               sub_i,
   input  logic [IDX_W-1:0]   idx_i,
   input  logic [WIN_W-1:0]   win_i,
   input  logic [IDX_W-1:0]   rd_idx_i,
   output logic [WORD_W-1:0]  rd_word_o,
   output logic [CARRY_W-1:0] rd_carry_o
);

   logic [WORD_W-1:0]  mem_q [NW];
   logic [NW-1:0]      vld_q;
   logic [CARRY_W-1:0] cry_q [NW];
   logic [IDX_W-1:0]   kidx  [WIN_N];
   logic [IDX_W-1:0]   cidx;
   logic [WIN_W-1:0]   cur;
   logic [WIN_W:0]     sum;

   always_comb begin
      for (int j = 0; j < WIN_N; j++) begin
         kidx[j] = idx_i + IDX_W'(j);
         cur[j*WORD_W +: WORD_W] = vld_q[kidx[j]] ? mem_q[kidx[j]] : '0;
      end
      cidx = idx_i + IDX_W'(WIN_N);
      sum  = sub_i ? ({1'b0, cur} - {1'b0, win_i}) : ({1'b0, cur} + {1'b0, win_i});
   end

   always_ff @(posedge clk_i) begin
      if (we_i && !clr_i) begin
         for (int j = 0; j < WIN_N; j++) begin
            mem_q[kidx[j]] <= sum[j*WORD_W +: WORD_W];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vld_q <= '0;
         for (int i = 0; i < NW; i++) cry_q[i] <= '0;
      end else if (clr_i) begin
         vld_q <= '0;
         for (int i = 0; i < NW; i++) cry_q[i] <= '0;
      end else if (we_i) begin
         for (int j = 0; j < WIN_N; j++) vld_q[kidx[j]] <= 1'b1;
         if (sum[WIN_W]) begin
            cry_q[cidx] <= sub_i ? cry_q[cidx] - CARRY_W'(1) : cry_q[cidx] + CARRY_W'(1);
         end
      end
   end

   assign rd_word_o  = vld_q[rd_idx_i] ? mem_q[rd_idx_i] : '0;
   assign rd_carry_o = cry_q[rd_idx_i];

endmodule

// File: rtl/xacc_final.sv
module xacc_final
   import xacc_pkg::*;
#(
   parameter int ACC_W   = 512,
   parameter int WORD_W  = 32,
   parameter int CARRY_W = 8,
   parameter int NBANK   = 4,
   parameter int FRAC_W  = 23,
   localparam int NW        = ACC_W / WORD_W,
   localparam int IDX_W     = $clog2(NW),
   localparam int OUT_EXP_W = $clog2(ACC_W) + 1,
   localparam int RES_W     = 1 + OUT_EXP_W + FRAC_W,
   localparam int SUM_W     = WORD_W + CARRY_W + $clog2(NBANK) + 2
) (
   input  logic                             clk_i,
   input  logic                             rst_ni,
   input  logic                             go_i,
   input  logic [NBANK-1:0][WORD_W-1:0]     rd_word_i,
   input  logic [NBANK-1:0][CARRY_W-1:0]    rd_carry_i,
   output logic [IDX_W-1:0]                 rd_idx_o,
   output logic                             busy_o,
   output logic [RES_W-1:0]                 res_o,
   output logic                             done_o
);

   fpass_e                   st_q;
   logic [IDX_W-1:0]         idx_q;
   logic signed [SUM_W-1:0]  cin_q, s;
   logic [ACC_W-1:0]         acc_q, mag, norm;
   logic                     neg, nz, grd, stk, up;
   logic [OUT_EXP_W-1:0]     lead, shamt, rexp;
   logic [FRAC_W:0]          rfrac;
   logic [RES_W-1:0]         rnd;

   always_comb begin
      s = cin_q;
      for (int b = 0; b < NBANK; b++) begin
         s = s + {{(SUM_W-WORD_W){1'b0}}, rd_word_i[b]}
               + {{(SUM_W-CARRY_W){rd_carry_i[b][CARRY_W-1]}}, rd_carry_i[b]};
      end
   end

   always_comb begin
      neg  = acc_q[ACC_W-1];
      mag  = neg ? (~acc_q + ACC_W'(1)) : acc_q;
      lead = '0;
      nz   = 1'b0;
      for (int i = 0; i < ACC_W; i++) begin
         if (mag[i]) begin
            lead = OUT_EXP_W'(i);
            nz   = 1'b1;
         end
      end
      shamt = OUT_EXP_W'(ACC_W - 1) - lead;
      norm  = mag << shamt;
      grd   = norm[ACC_W-2-FRAC_W];
      stk   = |norm[ACC_W-3-FRAC_W:0];
      up    = grd & (stk | norm[ACC_W-1-FRAC_W]);
      rfrac = {1'b0, norm[ACC_W-2 -: FRAC_W]} + (FRAC_W+1)'(up);
      rexp  = lead + OUT_EXP_W'(1) + OUT_EXP_W'(rfrac[FRAC_W]);
      rnd   = nz ? {neg, rexp, rfrac[FRAC_W-1:0]} : '0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= FP_IDLE;
         idx_q  <= '0;
         cin_q  <= '0;
         res_o  <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (st_q)
            FP_IDLE:  if (go_i) st_q <= FP_DRAIN;
            FP_DRAIN: begin
               st_q  <= FP_SUM;
               idx_q <= '0;
               cin_q <= '0;
            end
            FP_SUM: begin
               cin_q <= s >>> WORD_W;
               idx_q <= idx_q + IDX_W'(1);
               if (idx_q == IDX_W'(NW - 1)) st_q <= FP_ROUND;
            end
            default: begin
               res_o  <= rnd;
               done_o <= 1'b1;
               st_q   <= FP_IDLE;
            end
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (st_q == FP_SUM) acc_q[idx_q*WORD_W +: WORD_W] <= s[WORD_W-1:0];
   end

   assign rd_idx_o = idx_q;
   assign busy_o   = (st_q != FP_IDLE);

endmodule

// File: rtl/xacc_mac.sv
module xacc_mac #(
   parameter int EXP_W   = 7,
   parameter int FRAC_W  = 23,
   parameter int ACC_W   = 512,
   parameter int WORD_W  = 32,
   parameter int CARRY_W = 8,
   parameter int NBANK   = 4,
   localparam int OP_W      = 1 + EXP_W + FRAC_W,
   localparam int OUT_EXP_W = $clog2(ACC_W) + 1,
   localparam int RES_W     = 1 + OUT_EXP_W + FRAC_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              in_valid_i,
   input  logic [OP_W-1:0]   op_a_i,
   input  logic [OP_W-1:0]   op_b_i,
   input  logic              clear_i,
   input  logic              finish_i,
   output logic [RES_W-1:0]  res_o,
   output logic              done_o
);

   localparam int NW      = ACC_W / WORD_W;
   localparam int IDX_W   = $clog2(NW);
   localparam int SEL_W   = $clog2(NBANK);
   localparam int PROD_W  = 2 * (FRAC_W + 1);
   localparam int WIN_N   = (PROD_W + 2 * (WORD_W - 1)) / WORD_W;
   localparam int WIN_W   = WIN_N * WORD_W;
   localparam int MAX_POS = 2 * ((1 << EXP_W) - 1);

   if (NBANK < 2 || (NBANK & (NBANK - 1)) != 0) begin : g_bad_nbank
      $error("NBANK must be a power of two of at least 2");
   end
   if ((ACC_W % WORD_W) != 0 || (NW & (NW - 1)) != 0) begin : g_bad_words
      $error("ACC_W must be a power-of-two multiple of WORD_W");
   end
   if ((MAX_POS / WORD_W) + WIN_N > NW - 1) begin : g_bad_span
      $error("accumulator span too small for the exponent range");
   end

   logic                          fin_busy, fin_go, take, clr;
   logic [SEL_W-1:0]              rr_q;
   logic                          pv, psub;
   logic [IDX_W-1:0]              pidx, rd_idx;
   logic [WIN_W-1:0]              pwin;
   logic [SEL_W-1:0]              psel;
   logic [NBANK-1:0]              bank_we;
   logic [NBANK-1:0][WORD_W-1:0]  rd_word;
   logic [NBANK-1:0][CARRY_W-1:0] rd_cry;

   assign take   = in_valid_i & ~fin_busy;
   assign clr    = clear_i & ~fin_busy;
   assign fin_go = finish_i & ~fin_busy;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rr_q <= '0;
      else if (take) rr_q <= rr_q + SEL_W'(1);
   end

   xacc_prod #(
      .EXP_W(EXP_W), .FRAC_W(FRAC_W), .WORD_W(WORD_W),
      .WIN_N(WIN_N), .IDX_W(IDX_W), .SEL_W(SEL_W)
   ) u_prod (
      .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take),
      .op_a_i(op_a_i), .op_b_i(op_b_i), .sel_i(rr_q),
      .pv_o(pv), .psub_o(psub), .pidx_o(pidx), .pwin_o(pwin), .psel_o(psel)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign bank_we[b] = pv && (psel == SEL_W'(b));
      xacc_bank #(
         .NW(NW), .WORD_W(WORD_W), .CARRY_W(CARRY_W), .WIN_N(WIN_N), .IDX_W(IDX_W)
      ) u_bank (
         .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .we_i(bank_we[b]),
         .sub_i(psub), .idx_i(pidx), .win_i(pwin), .rd_idx_i(rd_idx),
         .rd_word_o(rd_word[b]), .rd_carry_o(rd_cry[b])
      );
   end

   xacc_final #(
      .ACC_W(ACC_W), .WORD_W(WORD_W), .CARRY_W(CARRY_W),
      .NBANK(NBANK), .FRAC_W(FRAC_W)
   ) u_final (
      .clk_i(clk_i), .rst_ni(rst_ni), .go_i(fin_go),
      .rd_word_i(rd_word), .rd_carry_i(rd_cry), .rd_idx_o(rd_idx),
      .busy_o(fin_busy), .res_o(res_o), .done_o(done_o)
   );

endmodule

// File: rtl/xacc_mac_chk.sv
module xacc_mac_chk #(
   parameter int NBANK     = 4,
   parameter int NW        = 16,
   parameter int RES_W     = 34,
   parameter int FRAC_W    = 23,
   parameter int OUT_EXP_W = 10
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [NBANK-1:0] we_i,
   input logic             go_i,
   input logic             busy_i,
   input logic             done_i,
   input logic [RES_W-1:0] res_i
);

   logic [15:0] since_go;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     since_go <= '0;
      else if (go_i)   since_go <= '0;
      else if (busy_i) since_go <= since_go + 16'd1;
   end

   assert_one_bank_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(we_i));

   assert_bank_rotates_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i != '0) |=> ((we_i & $past(we_i)) == '0));

   assert_zero_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i && res_i[RES_W-2 -: OUT_EXP_W] == '0) |-> (res_i == '0));

   assert_done_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |-> (since_go == 16'(NW + 2)));

   assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |=> !done_i);

   assert_res_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_i |-> $stable(res_i));

   assert_idle_at_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |-> !busy_i);

endmodule

bind xacc_mac xacc_mac_chk #(
   .NBANK(NBANK), .NW(NW), .RES_W(RES_W), .FRAC_W(FRAC_W), .OUT_EXP_W(OUT_EXP_W)
) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .we_i(bank_we), .go_i(fin_go),
   .busy_i(fin_busy), .done_i(done_o), .res_i(res_o)
);

// File: tb/tb_xacc_mac.sv
`timescale 1ns/1ps
module tb_xacc_mac;
   localparam int EXP_W = 7, FRAC_W = 23, ACC_W = 512, WORD_W = 32;
   localparam int NW = ACC_W / WORD_W;
   localparam int OUT_EXP_W = $clog2(ACC_W) + 1;
   localparam int OP_W = 1 + EXP_W + FRAC_W;
   localparam int RES_W = 1 + OUT_EXP_W + FRAC_W;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0, in_valid = 1'b0, clear = 1'b0, finish = 1'b0;
   logic [OP_W-1:0] op_a = '0, op_b = '0;
   logic [RES_W-1:0] res;
   logic done;

   xacc_mac dut (
      .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .op_a_i(op_a),
      .op_b_i(op_b), .clear_i(clear), .finish_i(finish), .res_o(res), .done_o(done)
   );

   int n_chk = 0, n_fail = 0;
   bit all_done = 0;
   logic [ACC_W-1:0] ref_acc = '0;

   function automatic logic [OP_W-1:0] mk(bit s, int e, int f);
      return {s, EXP_W'(e), FRAC_W'(f)};
   endfunction

   function automatic logic [ACC_W-1:0] term(logic [OP_W-1:0] a, logic [OP_W-1:0] b);
      logic [ACC_W-1:0] v;
      int ea, eb;
      ea = int'(a[OP_W-2 -: EXP_W]);
      eb = int'(b[OP_W-2 -: EXP_W]);
      if (ea == 0 || eb == 0) return '0;
      v = ACC_W'({1'b1, a[FRAC_W-1:0]}) * ACC_W'({1'b1, b[FRAC_W-1:0]});
      v = v << (ea + eb);
      if (a[OP_W-1] ^ b[OP_W-1]) v = -v;
      return v;
   endfunction

   function automatic logic [RES_W-1:0] rnd(logic [ACC_W-1:0] acc);
      logic neg;
      logic [ACC_W-1:0] mag, q, rem, half;
      logic [FRAC_W:0] fr;
      int lead, ex;
      neg  = acc[ACC_W-1];
      mag  = neg ? -acc : acc;
      lead = -1;
      for (int i = 0; i < ACC_W; i++) if (mag[i]) lead = i;
      if (lead < 0) return '0;
      if (lead > FRAC_W) begin
         int d;
         d    = lead - FRAC_W;
         q    = mag >> d;
         rem  = mag & ((ACC_W'(1) << d) - ACC_W'(1));
         half = ACC_W'(1) << (d - 1);
         fr   = {1'b0, q[FRAC_W-1:0]};
         if (rem > half || (rem == half && q[0])) fr = fr + 1'b1;
      end else begin
         q  = mag << (FRAC_W - lead);
         fr = {1'b0, q[FRAC_W-1:0]};
      end
      ex = lead + 1;
      if (fr[FRAC_W]) begin
         ex++;
         fr = '0;
      end
      return {neg, OUT_EXP_W'(ex), fr[FRAC_W-1:0]};
   endfunction

   task automatic chk(string req, string what, logic [ACC_W-1:0] act, logic [ACC_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic push(logic [OP_W-1:0] a, logic [OP_W-1:0] b, bit clr);
      in_valid = 1'b1; op_a = a; op_b = b; clear = clr;
      if (clr) ref_acc = '0;
      ref_acc = ref_acc + term(a, b);
      tick();
      in_valid = 1'b0; clear = 1'b0;
   endtask

   task automatic noise(int k);
      in_valid = 1'b1;
      op_a = mk(k[0], 60 + k, $urandom);
      op_b = mk(1'b0, 50, $urandom);
      clear = (k == 2);
      finish = 1'b1;
   endtask

   task automatic run_finish(string req, bit noisy);
      int cnt;
      logic [RES_W-1:0] got;
      finish = 1'b1;
      tick();
      in_valid = 1'b0; finish = 1'b0;
      cnt = 0;
      if (noisy) noise(0);
      for (int k = 0; k < 64; k++) begin
         @(posedge clk);
         cnt++;
         @(negedge clk);
         if (done) break;
         if (noisy) noise(cnt);
      end
      in_valid = 1'b0; clear = 1'b0; finish = 1'b0;
      chk({"R7 ", req}, "cycles to done", ACC_W'(cnt), ACC_W'(NW + 2));
      chk(req, "result", ACC_W'(res), ACC_W'(rnd(ref_acc)));
      got = res;
      tick();
      chk("R8", "done pulse width", ACC_W'(done), '0);
      chk("R8", "result held", ACC_W'(res), ACC_W'(got));
   endtask

   task automatic cancel_round(int emin, int espan, int n);
      logic [OP_W-1:0] sa [40];
      logic [OP_W-1:0] sb [40];
      for (int i = 0; i < n; i++) begin
         sa[i] = mk($urandom_range(1), emin + $urandom_range(espan), $urandom);
         sb[i] = mk($urandom_range(1), emin + $urandom_range(espan), $urandom);
         push(sa[i], sb[i], i == 0);
      end
      for (int i = n - 1; i >= 2; i--) begin
         push(sa[i] ^ {1'b1, {(OP_W-1){1'b0}}}, sb[i], 1'b0);
      end
      push(mk(1, 3, $urandom), mk(0, 2, $urandom), 1'b0);
      run_finish("R1 cancellation", 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!all_done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      tick();
      chk("R8", "reset done", ACC_W'(done), '0);
      chk("R8", "reset result", ACC_W'(res), '0);

      // R6: empty sum gives all-zero code
      run_finish("R6 empty", 1'b0);

      // R2: zero-exponent operands contribute nothing
      push(mk(0, 0, 123), mk(0, 90, 5), 1'b1);
      push(mk(1, 40, 7), mk(0, 0, 9), 1'b0);
      push(mk(0, 30, 1000), mk(0, 31, 77), 1'b0);
      run_finish("R2 zero operands", 1'b0);
      chk("R2", "explicit value", ACC_W'(res), ACC_W'(rnd(term(mk(0, 30, 1000), mk(0, 31, 77)))));

      // R11: tie with even fraction rounds down, tie with odd fraction rounds up
      push(mk(0, 50, 0), mk(0, 50, 0), 1'b1);
      push(mk(0, 38, 0), mk(0, 38, 0), 1'b0);
      run_finish("R11 tie even", 1'b0);
      chk("R11", "tie to even", ACC_W'(res), ACC_W'({1'b0, OUT_EXP_W'(147), FRAC_W'(0)}));
      push(mk(0, 50, 0), mk(0, 50, 0), 1'b1);
      push(mk(0, 38, 0), mk(0, 39, 0), 1'b0);
      push(mk(0, 38, 0), mk(0, 38, 0), 1'b0);
      run_finish("R11 tie odd", 1'b0);
      chk("R11", "tie rounds up", ACC_W'(res), ACC_W'({1'b0, OUT_EXP_W'(147), FRAC_W'(2)}));
      push(mk(0, 50, 23'h7fffff), mk(0, 50, 23'h7fffff), 1'b1);
      run_finish("R11 carry into exponent", 1'b0);

      // R4: negative total
      push(mk(0, 20, 11), mk(0, 20, 3), 1'b1);
      push(mk(1, 30, 99), mk(0, 30, 4), 1'b0);
      run_finish("R4 negative", 1'b0);
      chk("R4", "sign bit", ACC_W'(res[RES_W-1]), ACC_W'(1));

      // R1: heavy cancellation, wide and narrow exponent spread
      cancel_round(1, 120, 36);
      cancel_round(55, 6, 36);
      cancel_round(10, 40, 30);

      // R3: identical pairs every cycle, all counted, carries stacked
      push(mk(0, 70, 23'h7fffff), mk(0, 60, 23'h7ffff0), 1'b1);
      for (int i = 0; i < 15; i++) push(mk(0, 70, 23'h7fffff), mk(0, 60, 23'h7ffff0), 1'b0);
      run_finish("R3 back-to-back", 1'b0);

      // R10: finish leaves the sum; more pairs add on
      push(mk(1, 62, 321), mk(0, 65, 4321), 1'b0);
      push(mk(0, 5, 1), mk(0, 6, 2), 1'b0);
      run_finish("R10 continue after finish", 1'b0);

      // R9: inputs during the pass are ignored, then a clean repeat matches
      run_finish("R9 noisy pass", 1'b1);
      run_finish("R9 repeat", 1'b0);

      // R5: pair before clear dropped, pair with clear kept
      push(mk(0, 100, 555), mk(0, 100, 666), 1'b0);
      push(mk(1, 12, 77), mk(0, 13, 88), 1'b1);
      run_finish("R5 clear collision", 1'b0);
      chk("R5", "only pair with clear", ACC_W'(res), ACC_W'(rnd(term(mk(1, 12, 77), mk(0, 13, 88)))));

      // R7: pair presented together with finish is included
      in_valid = 1'b1; op_a = mk(0, 45, 9); op_b = mk(1, 44, 10);
      ref_acc = ref_acc + term(op_a, op_b);
      run_finish("R7 pair with finish", 1'b0);

      all_done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule